// File: doc/BRIEF.md
# Dual-Channel Serial Audio Word Receiver

This block takes in two serial audio streams, one for the left channel and one for the right, that share a single bit clock. Each channel shifts its data pin into its own shift register on every rising bit-clock edge. When that channel's load strobe falls, the block copies the 18 most recently shifted bits into the channel's parallel output word. That word would then feed a conversion core. No bit counter is involved: the falling load strobe alone marks where a word ends.

All five serial pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser, and its edges are then detected in the system clock domain. The system clock must run at least four times faster than the bit clock. Each output word is an 18-bit two's-complement value and comes with a strobe one cycle wide. Tying the two load pins together updates both channels in the same cycle. Tying the two data pins together gives both channels the same word.

Top module: `serial_dac_rx`

## Requirements
- R1: After reset, both output words are 0 (two's-complement midscale), both strobes are low, and both shift registers are empty, so a load edge with no bits shifted in yields 0.
- R2: A data bit is taken only on a rising bit-clock edge. Data changes while the bit clock is low or falling shift nothing.
- R3: A falling edge on a channel's load pin copies that channel's last 18 shifted bits into its word. The most recent bit lands in bit 0, so a word sent MSB first appears unchanged.
- R4: If more than 18 bits arrive before a load edge, only the 18 most recent bits are kept.
- R5: If fewer than 18 bits arrive, the word is made of the new bits in the low positions and older, still-held bits above them.
- R6: A load edge on one channel leaves the other channel's word and strobe unchanged.
- R7: A channel's strobe is high for exactly one cycle, together with its new word. The word does not change at any other time, and a rising load edge has no effect.
- R8: Load pins driven together update both channels in the same cycle. Data pins driven together produce equal words.
- R9: If a rising bit-clock edge and a falling load edge reach the system domain in the same cycle, the bit from that rising edge is part of the loaded word.
- R10: The strobe rises after the third rising system-clock edge that follows the load pin's fall.
- R11: The receiver works correctly with a bit-clock period of four system clocks, and also with slower bit clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_in | input | 1 | Shared serial bit clock (asynchronous) |
| dat_l_in | input | 1 | Left serial data |
| dat_r_in | input | 1 | Right serial data |
| lat_l_in | input | 1 | Left load strobe, acts on its falling edge |
| lat_r_in | input | 1 | Right load strobe, acts on its falling edge |
| word_l | output | 18 | Left parallel word, two's complement |
| upd_l | output | 1 | Left new-word strobe |
| word_r | output | 18 | Right parallel word, two's complement |
| upd_r | output | 1 | Right new-word strobe |

## Verification
Two events can fall in the same system cycle: a bit shift and a word load. The bench provokes this by raising the bit clock and lowering the load pin on the same system-clock edge for the 18th bit. The loaded word must then contain that final bit (R9), with the bench's cycle model and a fixed expected word both checking it. A second collision, both channels loading in one cycle, is provoked with load pins driven together. Both strobes must rise at the same sampling point.

// File: rtl/serial_dac_rx.sv
module serial_dac_rx #(
  parameter int WORD_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_in,
  input  logic              dat_l_in,
  input  logic              dat_r_in,
  input  logic              lat_l_in,
  input  logic              lat_r_in,
  output logic [WORD_W-1:0] word_l,
  output logic              upd_l,
  output logic [WORD_W-1:0] word_r,
  output logic              upd_r
);
  localparam int NPIN = 5;
  localparam int P_BCK = 0;
  localparam int P_DL  = 1;
  localparam int P_DR  = 2;
  localparam int P_LL  = 3;
  localparam int P_LR  = 4;

  logic [NPIN-1:0] raw, sy, prv;
  logic [NPIN-1:0] stg [SYNC_STAGES];

  assign raw = {lat_r_in, lat_l_in, dat_r_in, dat_l_in, bclk_in};

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= raw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign sy = stg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prv <= '0;
    else        prv <= sy;

  logic bit_rise, fall_l, fall_r;
  assign bit_rise = sy[P_BCK] & ~prv[P_BCK];
  assign fall_l   = prv[P_LL] & ~sy[P_LL];
  assign fall_r   = prv[P_LR] & ~sy[P_LR];

  logic [WORD_W-1:0] sh_l, sh_r, sh_l_nx, sh_r_nx;
  assign sh_l_nx = bit_rise ? {sh_l[WORD_W-2:0], sy[P_DL]} : sh_l;
  assign sh_r_nx = bit_rise ? {sh_r[WORD_W-2:0], sy[P_DR]} : sh_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_l <= '0;
      sh_r <= '0;
    end else begin
      sh_l <= sh_l_nx;
      sh_r <= sh_r_nx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_l <= '0;
      upd_l  <= 1'b0;
    end else begin
      upd_l <= fall_l;
      if (fall_l) word_l <= sh_l_nx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_r <= '0;
      upd_r  <= 1'b0;
    end else begin
      upd_r <= fall_r;
      if (fall_r) word_r <= sh_r_nx;
    end
endmodule

// File: rtl/serial_dac_rx_chk.sv
module serial_dac_rx_chk #(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lat_l_in,
  input logic              lat_r_in,
  input logic [WORD_W-1:0] word_l,
  input logic              upd_l,
  input logic [WORD_W-1:0] word_r,
  input logic              upd_r
);
  AST_RESET_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (word_l == '0 && word_r == '0 && !upd_l && !upd_r)); // R1

  AST_STROBE_PULSE_L: assert property (@(posedge clk) disable iff (!rst_n)
    upd_l |=> !upd_l); // R7

  AST_STROBE_PULSE_R: assert property (@(posedge clk) disable iff (!rst_n)
    upd_r |=> !upd_r); // R7

  AST_HOLD_L: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_l) |-> upd_l); // R6

  AST_HOLD_R: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_r) |-> upd_r); // R6

  AST_LATENCY_L: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_l) |-> ($past(lat_l_in, 3) == 1'b0 && $past(lat_l_in, 4) == 1'b1)); // R10

  AST_LATENCY_R: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_r) |-> ($past(lat_r_in, 3) == 1'b0 && $past(lat_r_in, 4) == 1'b1)); // R10
endmodule

bind serial_dac_rx serial_dac_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lat_l_in(lat_l_in), .lat_r_in(lat_r_in),
  .word_l(word_l), .upd_l(upd_l), .word_r(word_r), .upd_r(upd_r)
);

// File: tb/test_serial_dac_rx.sv
`timescale 1ns/1ps
module test_serial_dac_rx;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, dl = 1'b0, dr = 1'b0, ll = 1'b1, lr = 1'b1;
  logic [W-1:0] word_l, word_r;
  logic upd_l, upd_r;

  int total = 0;
  int bad = 0;
  int hb = 2;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_dac_rx i_serial_dac_rx (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .dat_l_in(dl), .dat_r_in(dr),
    .lat_l_in(ll), .lat_r_in(lr), .word_l(word_l), .upd_l(upd_l),
    .word_r(word_r), .upd_r(upd_r)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // cycle-level behavioural reference: pins seen two clocks late, edges one more
  logic [4:0] h [4];
  logic [W-1:0] m_shl, m_shr, m_wl, m_wr;
  logic m_ul, m_ur;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) h[i] = '0;
      m_shl = '0; m_shr = '0; m_wl = '0; m_wr = '0; m_ul = 0; m_ur = 0;
    end else begin
      for (int i = 3; i > 0; i--) h[i] = h[i-1];
      h[0] = {lr, ll, dr, dl, bclk};
      m_ul = 0; m_ur = 0;
      if (h[2][0] && !h[3][0]) begin
        m_shl = {m_shl[W-2:0], h[2][1]};
        m_shr = {m_shr[W-2:0], h[2][2]};
      end
      if (h[3][3] && !h[2][3]) begin m_wl = m_shl; m_ul = 1; end
      if (h[3][4] && !h[2][4]) begin m_wr = m_shr; m_ur = 1; end
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R3 model word_l", word_l, m_wl);
    chk("R3 model word_r", word_r, m_wr);
    chk("R7 model upd_l", upd_l, m_ul);
    chk("R7 model upd_r", upd_r, m_ur);
  end

  task automatic send_bit(input logic bl, input logic br);
    @(negedge clk); dl = bl; dr = br; bclk = 1'b0;
    repeat (hb) @(negedge clk);
    bclk = 1'b1;
    repeat (hb - 1) @(negedge clk);
  endtask

  task automatic send_words(input logic [W-1:0] a, input logic [W-1:0] b);
    for (int i = W - 1; i >= 0; i--) send_bit(a[i], b[i]);
    @(negedge clk); bclk = 1'b0;
  endtask

  // drop selected load pins, check strobe timing (R10), release
  task automatic load(input logic sl, input logic sr, input string rq);
    @(negedge clk);
    if (sl) ll = 1'b0;
    if (sr) lr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({rq, " R10 strobe early L"}, upd_l, 1'b0);
    chk({rq, " R10 strobe early R"}, upd_r, 1'b0);
    @(negedge clk);
    chk({rq, " R10 strobe L"}, upd_l, sl);
    chk({rq, " R10 strobe R"}, upd_r, sr);
    ll = 1'b1; lr = 1'b1;
    repeat (4) @(negedge clk);
    chk({rq, " R7 rising load no strobe"}, {upd_l, upd_r}, 2'b00);
  endtask

  initial begin
    logic [W-1:0] a, b, last;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word_l", word_l, '0);
    chk("R1 reset word_r", word_r, '0);
    chk("R1 reset strobes", {upd_l, upd_r}, 2'b00);
    repeat (3) @(negedge clk);
    load(1, 1, "R1 empty shift");
    chk("R1 empty shift word_l", word_l, '0);
    chk("R1 empty shift word_r", word_r, '0);

    a = 18'h2A5C3; b = 18'h1F00E;
    send_words(a, b);
    load(1, 0, "R3 left");
    chk("R3 word_l MSB first", word_l, a);
    chk("R6 word_r untouched", word_r, '0);
    load(0, 1, "R6 right");
    chk("R3 word_r", word_r, b);
    chk("R6 word_l held", word_l, a);

    // R2: data toggles with bit clock low shift nothing
    repeat (6) begin @(negedge clk); dl = ~dl; dr = ~dr; end
    load(1, 1, "R2");
    chk("R2 no shift without rising bclk L", word_l, a);
    chk("R2 no shift without rising bclk R", word_r, b);

    // R4: 22 bits, keep last 18
    send_bit(1, 0); send_bit(0, 1); send_bit(1, 1); send_bit(1, 0);
    a = 18'h3C3C3; b = 18'h00FF1;
    send_words(a, b);
    load(1, 1, "R4 R8");
    chk("R4 overflow keeps last 18 L", word_l, a);
    chk("R4 overflow keeps last 18 R", word_r, b);

    // R5: 4 new bits over held bits
    send_bit(0, 1); send_bit(1, 1); send_bit(0, 0); send_bit(1, 0);
    @(negedge clk); bclk = 1'b0;
    load(1, 1, "R5");
    chk("R5 partial word L", word_l, {a[W-5:0], 4'b0101});
    chk("R5 partial word R", word_r, {b[W-5:0], 4'b1100});

    // R8: shared data
    a = 18'h25A5A;
    send_words(a, a);
    load(1, 1, "R8 shared");
    chk("R8 shared data equal", {14'd0, word_l}, {14'd0, word_r});
    chk("R8 shared data value", word_l, a);

    // R9: last rising bclk and load fall in same cycle
    a = 18'h30F0F; b = 18'h0ABCD;
    for (int i = W - 1; i >= 1; i--) send_bit(a[i], b[i]);
    @(negedge clk); dl = a[0]; dr = b[0]; bclk = 1'b0;
    repeat (hb) @(negedge clk);
    bclk = 1'b1; ll = 1'b0; lr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 coincident strobe", {upd_l, upd_r}, 2'b11);
    chk("R9 coincident word L", word_l, a);
    chk("R9 coincident word R", word_r, b);
    ll = 1'b1; lr = 1'b1;
    @(negedge clk); bclk = 1'b0;
    repeat (4) @(negedge clk);

    // R11: slower bit clock
    hb = 5;
    a = 18'h12345; b = 18'h3FFFF;
    send_words(a, b);
    load(1, 1, "R11 slow");
    chk("R11 slow bclk L", word_l, a);
    chk("R11 slow bclk R", word_r, b);
    last = word_l;
    chk("R7 word held", word_l, last);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule